// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block gathers a set of single-bit status conditions into one interrupt pin and one overflow pin. Each condition can be made to latch on a rising edge or a falling edge, or it can simply follow its current level. A mask bit per condition decides whether that condition can raise the interrupt. Latched edge events stay set until the host reads the status register. The read itself clears them. An edge that lands in the same cycle as that read is kept for the next read.

Two of the sources are reserved as the overflow and underflow conditions. Their OR drives an open-drain, active-low overflow pin, and the interrupt masks have no effect on that pin. The interrupt pin is given as a data/output-enable pair. It can run as an active-high push-pull output, or as an active-low open-drain output that never drives high, so that several devices can share one host interrupt line. Software reaches the block through a plain register bus. The write is taken on the clock edge. Read data appears one cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every source is masked (mask register reads all ones), every source is in level mode, the pin runs in active-low open-drain mode (mode register reads 0), and int_oe and int_data are both low.
- R2: A source in level mode (its bit in the edge-select register at address 0x1 is 0) shows its input value in status bit i one clock after that value was sampled.
- R3: A source in edge mode with its falling-select bit (address 0x2) at 0 sets status bit i when the input goes from 0 to 1. The bit then stays set until the status register is read.
- R4: A source in edge mode with its falling-select bit at 1 sets status bit i when the input goes from 1 to 0.
- R5: A read at address 0xD returns the status register on rdata in the next cycle and clears all edge-mode status bits. Level-mode bits keep following their inputs.
- R6: An edge event that is detected in the same cycle as a status read stays set after the clear.
- R7: The interrupt is asserted exactly when some status bit is set while its mask bit (address 0x0, 1 = blocked) is 0.
- R8: With pin-mode bit 0 (address 0x3) at 1, int_oe is held at 1 and int_data equals the interrupt state.
- R9: With pin-mode bit 0 at 0, int_data is held at 0 and int_oe equals the interrupt state.
- R10: ovf_data is always 0, and ovf_oe is 1 exactly when status bit 6 (overflow) or status bit 7 (underflow) is set, whatever the masks hold.
- R11: Writes to address 0xD have no effect on the status register.
- R12: Mask, edge-select, falling-select and pin-mode registers read back what was written. Addresses that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| src_in | input | 8 | Synchronous status conditions; bit 6 is overflow, bit 7 is underflow |
| int_data | output | 1 | Interrupt pin drive value |
| int_oe | output | 1 | Interrupt pin output enable |
| ovf_data | output | 1 | Overflow pin drive value (always low) |
| ovf_oe | output | 1 | Overflow pin output enable (pulls low when active) |

## Verification
The properties assume that src_in is already synchronous to clk and changes only between edges. They also assume a status read and a configuration write to the edge-select register of the same source are never meant to interact beyond one cycle. The bench drives every input on the falling clock edge, so each posedge samples settled values. It mixes directed sequences, which put an edge exactly on a read cycle and write to the read-only address, with random source toggling, reads and reconfiguration. Every value it drives stays within the eight defined sources and the mapped and unmapped addresses.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_MASK = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_EDGE = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_FALL = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_PMOD = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_STAT = 4'hD;

  // Event on the chosen transition between the previous and current sample.
  function automatic logic edge_hit(input logic prev, input logic cur, input logic on_fall);
    return on_fall ? (prev & ~cur) : (~prev & cur);
  endfunction

  // Pad pair {data, oe} for an interrupt state and pin mode.
  function automatic logic [1:0] pad_pair(input logic active, input logic push_pull);
    return push_pull ? {active, 1'b1} : {1'b0, active};
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_agg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      status_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      edge_q,
  output logic [N-1:0]      fall_q,
  output logic              pol_q,
  output logic [N-1:0]      rdata,
  output logic              rd_clr
);
  logic [N-1:0] rd_mux;

  assign rd_clr = rd_en && (addr == ADR_STAT);

  always_comb begin
    case (addr)
      ADR_MASK: rd_mux = mask_q;
      ADR_EDGE: rd_mux = edge_q;
      ADR_FALL: rd_mux = fall_q;
      ADR_PMOD: rd_mux = {{(N-1){1'b0}}, pol_q};
      ADR_STAT: rd_mux = status_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      edge_q <= '0;
      fall_q <= '0;
      pol_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_en) begin
        if (addr == ADR_MASK) mask_q <= wdata;
        if (addr == ADR_EDGE) edge_q <= wdata;
        if (addr == ADR_FALL) fall_q <= wdata;
        if (addr == ADR_PMOD) pol_q  <= wdata[0];
      end
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import irq_agg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] edge_q,
  input  logic [N-1:0] fall_q,
  input  logic         rd_clr,
  output logic [N-1:0] status_q,
  output logic [N-1:0] evt
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_in;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    assign evt[i] = edge_q[i] & edge_hit(src_q[i], src_in[i], fall_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        status_q[i] <= 1'b0;
      else if (edge_q[i])
        status_q[i] <= (status_q[i] & ~rd_clr) | evt[i];
      else
        status_q[i] <= src_in[i];
    end
  end
endmodule

// File: rtl/irq_drive.sv
module irq_drive
  import irq_agg_pkg::*;
#(
  parameter int N       = 8,
  parameter int OVF_IDX = 6,
  parameter int UNF_IDX = 7
) (
  input  logic [N-1:0] status_q,
  input  logic [N-1:0] mask_q,
  input  logic         pol_q,
  output logic         irq_any,
  output logic         int_data,
  output logic         int_oe,
  output logic         ovf_data,
  output logic         ovf_oe
);
  assign irq_any = |(status_q & ~mask_q);
  assign {int_data, int_oe} = pad_pair(irq_any, pol_q);
  assign ovf_data = 1'b0;
  assign ovf_oe   = status_q[OVF_IDX] | status_q[UNF_IDX];
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N       = 8,
  parameter int OVF_IDX = 6,
  parameter int UNF_IDX = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  input  logic [N-1:0]      src_in,
  output logic              int_data,
  output logic              int_oe,
  output logic              ovf_data,
  output logic              ovf_oe
);
  logic [N-1:0] mask_q, edge_q, fall_q, status_q, evt;
  logic         pol_q, rd_clr, irq_any;

  irq_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status_q(status_q), .mask_q(mask_q), .edge_q(edge_q),
    .fall_q(fall_q), .pol_q(pol_q), .rdata(rdata), .rd_clr(rd_clr)
  );

  irq_detect #(.N(N)) u_detect (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_q(edge_q),
    .fall_q(fall_q), .rd_clr(rd_clr), .status_q(status_q), .evt(evt)
  );

  irq_drive #(.N(N), .OVF_IDX(OVF_IDX), .UNF_IDX(UNF_IDX)) u_drive (
    .status_q(status_q), .mask_q(mask_q), .pol_q(pol_q), .irq_any(irq_any),
    .int_data(int_data), .int_oe(int_oe), .ovf_data(ovf_data), .ovf_oe(ovf_oe)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N       = 8,
  parameter int OVF_IDX = 6,
  parameter int UNF_IDX = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] src_in,
  input logic [N-1:0] status_q,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] edge_q,
  input logic [N-1:0] evt,
  input logic         pol_q,
  input logic         rd_clr,
  input logic         int_data,
  input logic         int_oe,
  input logic         ovf_data,
  input logic         ovf_oe
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_q[i] |=> (status_q[i] == $past(src_in[i])));
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && edge_q[i] && !rd_clr) |=> status_q[i]);
    a_r6_keep_event: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> status_q[i]);
  end

  a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !(pol_q ? int_data : int_oe));
  a_r8_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
    pol_q |-> int_oe);
  a_r9_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_q |-> !int_data);
  a_r10_ovf_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[OVF_IDX] || status_q[UNF_IDX]) |-> (ovf_oe && !ovf_data));
  a_r10_ovf_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_data);
endmodule

bind irq_aggregator irq_aggregator_chk #(.N(N), .OVF_IDX(OVF_IDX), .UNF_IDX(UNF_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .status_q(status_q), .mask_q(mask_q),
  .edge_q(edge_q), .evt(evt), .pol_q(pol_q), .rd_clr(rd_clr), .int_data(int_data),
  .int_oe(int_oe), .ovf_data(ovf_data), .ovf_oe(ovf_oe)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [N-1:0] wdata = '0, src_in = '0;
  logic [N-1:0] rdata;
  logic int_data, int_oe, ovf_data, ovf_oe;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  logic [N-1:0] m_mask, m_edge, m_fall, m_stat, m_srcq, m_rdata;
  logic m_pol;

  always #2.5 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_in(src_in), .int_data(int_data),
    .int_oe(int_oe), .ovf_data(ovf_data), .ovf_oe(ovf_oe)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '1; m_edge = '0; m_fall = '0; m_pol = 0;
      m_stat = '0; m_srcq = '0; m_rdata = '0;
    end else begin
      logic [N-1:0] nstat;
      logic clr;
      clr = rd_en && addr == 4'hD;
      for (int i = 0; i < N; i++) begin
        bit ev;
        ev = m_fall[i] ? (m_srcq[i] && !src_in[i]) : (!m_srcq[i] && src_in[i]);
        if (m_edge[i]) nstat[i] = (m_stat[i] && !clr) || ev;
        else           nstat[i] = src_in[i];
      end
      if (rd_en) begin
        case (addr)
          4'h0: m_rdata = m_mask;
          4'h1: m_rdata = m_edge;
          4'h2: m_rdata = m_fall;
          4'h3: m_rdata = {7'b0, m_pol};
          4'hD: m_rdata = m_stat;
          default: m_rdata = '0;
        endcase
      end
      if (wr_en) begin
        case (addr)
          4'h0: m_mask = wdata;
          4'h1: m_edge = wdata;
          4'h2: m_fall = wdata;
          4'h3: m_pol  = wdata[0];
          default: ;
        endcase
      end
      m_stat = nstat;
      m_srcq = src_in;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit act;
      act = (m_stat & ~m_mask) != 0;
      check({tag, " R7 R8 R9 int_data"}, {7'b0, int_data}, {7'b0, m_pol ? act : 1'b0});
      check({tag, " R7 R8 R9 int_oe"}, {7'b0, int_oe}, {7'b0, m_pol ? 1'b1 : act});
      check({tag, " R10 ovf_oe"}, {7'b0, ovf_oe}, {7'b0, m_stat[6] | m_stat[7]});
      check({tag, " R10 ovf_data"}, {7'b0, ovf_data}, 8'h00);
      check({tag, " rdata"}, rdata, m_rdata);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    check("R1 int_oe", {7'b0, int_oe}, 8'h00);
    check("R1 int_data", {7'b0, int_data}, 8'h00);
    rd(4'h0); check("R1 mask", rdata, 8'hFF);
    rd(4'h1); check("R1 edge", rdata, 8'h00);
    rd(4'h3); check("R1 pin mode", rdata, 8'h00);

    // R12: readback, unmapped address
    tag = "R12";
    wr(4'h2, 8'hA5); rd(4'h2); check("R12 fall", rdata, 8'hA5);
    wr(4'h2, 8'h00); wr(4'h0, 8'h3C); rd(4'h0); check("R12 mask", rdata, 8'h3C);
    rd(4'h7); check("R12 unmapped", rdata, 8'h00);

    // R2/R7: level mode, open-drain
    tag = "R2";
    wr(4'h0, 8'h00);
    src_in = 8'h05; idle(1); src_in = 8'h00;
    check("R2 int_oe after level high", {7'b0, int_oe}, 8'h01);
    idle(1);
    check("R2 level released", {7'b0, int_oe}, 8'h00);
    tag = "R7";
    wr(4'h0, 8'hFE); src_in = 8'h02; idle(2);
    check("R7 masked source quiet", {7'b0, int_oe}, 8'h00);
    src_in = 8'h03; idle(2);
    check("R7 unmasked source drives", {7'b0, int_oe}, 8'h01);
    src_in = 8'h00; idle(2);

    // R3: rising edge sticky
    tag = "R3";
    wr(4'h0, 8'h00); wr(4'h1, 8'h0F); wr(4'h2, 8'h00);
    src_in = 8'h01; idle(1); src_in = 8'h00; idle(3);
    check("R3 sticky after pulse", {7'b0, int_oe}, 8'h01);
    rd(4'hD); check("R3 status bit0", rdata, 8'h01);

    // R5: read clears edge bits, not level bits
    tag = "R5";
    check("R5 cleared by read", {7'b0, int_oe}, 8'h00);
    src_in = 8'h10; idle(1);
    rd(4'hD); check("R5 level bit kept", rdata, 8'h10);
    rd(4'hD); check("R5 level bit still follows", rdata, 8'h10);
    src_in = 8'h00; idle(2);

    // R4: falling edge
    tag = "R4";
    wr(4'h2, 8'h04); src_in = 8'h04; idle(2);
    rd(4'hD); check("R4 no event on rise", rdata, 8'h00);
    src_in = 8'h00; idle(2);
    rd(4'hD); check("R4 event on fall", rdata, 8'h04);

    // R6: edge during status read
    tag = "R6";
    wr(4'h2, 8'h00);
    src_in = 8'h01; idle(1);
    src_in = 8'h03; rd_en = 1; addr = 4'hD; idle(1); rd_en = 0;
    check("R6 first read", rdata, 8'h01);
    rd(4'hD); check("R6 event kept", rdata, 8'h02);
    src_in = 8'h00; idle(2);

    // R11: write to status ignored
    tag = "R11";
    src_in = 8'h01; idle(1); src_in = 8'h00; idle(1);
    wr(4'hD, 8'h00); wr(4'hD, 8'hFF);
    rd(4'hD); check("R11 status unchanged", rdata, 8'h01);

    // R8: push-pull
    tag = "R8";
    wr(4'h3, 8'h01);
    check("R8 oe held", {7'b0, int_oe}, 8'h01);
    check("R8 data idle", {7'b0, int_data}, 8'h00);
    src_in = 8'h02; idle(1); src_in = 8'h00; idle(1);
    check("R8 data high", {7'b0, int_data}, 8'h01);
    rd(4'hD);
    tag = "R9";
    wr(4'h3, 8'h00);
    check("R9 data low", {7'b0, int_data}, 8'h00);

    // R10: overflow pin ignores masks
    tag = "R10";
    wr(4'h0, 8'hFF); wr(4'h1, 8'h00);
    src_in = 8'h40; idle(2);
    check("R10 overflow", {7'b0, ovf_oe}, 8'h01);
    check("R10 int masked", {7'b0, int_oe}, 8'h00);
    src_in = 8'h80; idle(2);
    check("R10 underflow", {7'b0, ovf_oe}, 8'h01);
    src_in = 8'h00; idle(2);
    check("R10 released", {7'b0, ovf_oe}, 8'h00);

    // random mix, checked each cycle by the model
    tag = "RND R2 R3 R4 R5 R6";
    for (int k = 0; k < 3000; k++) begin
      int sel;
      sel = $urandom_range(0, 15);
      src_in = N'($urandom);
      rd_en = (sel < 4);
      wr_en = (sel == 5);
      addr = (sel < 3) ? 4'hD : 4'($urandom_range(0, 15));
      wdata = N'($urandom);
      @(negedge clk);
    end
    rd_en = 0; wr_en = 0;
    idle(2);
    finish_run();
  end
endmodule